// File: doc/BRIEF.md
# Programmable Parallel Bus Cycle Sequencer

This block drives one chip select of an external memory-mapped parallel bus. A request taken on the internal valid/ready port becomes one external cycle of five phases in a fixed sequence: address, chip-select setup, strobe, hold and recovery. Each phase lasts one clock plus its own programmable extension count. The configuration arrives on static inputs. It selects the strobe signalling style, whether the address is multiplexed onto the data pins, the external width (16 or 8 bits), whether byte reads on a 16-bit device go out as single-byte accesses, and whether writes are allowed.

The request carries a byte address, write data, byte enables and a read flag. Exactly one response is returned for each accepted request. It is a one-clock pulse carrying the read data and an error flag, and it appears in the first idle clock after recovery ends. The request port is ready only while no cycle is in progress.

Top module: `pbus_cycle_seq`

## Requirements
- R1: After a request is accepted, the phases occur in this order: address for 1+`cfg_ext_addr` clocks, setup for 1+`cfg_ext_setup` clocks, strobe for 1+`cfg_ext_strobe` clocks, hold for 1+`cfg_ext_hold` clocks, then recovery for 1+`cfg_ext_recov` clocks. `req_ready` is low from the clock after acceptance until recovery ends, and high otherwise.
- R2: `bus_cs_n` is low exactly during the setup, strobe and hold phases, and `bus_addr` is stable while it is low.
- R3: With `cfg_style` 0, and also with the reserved value 3, `bus_rd_n` is low during the strobe phase of a read and `bus_wr_n` is low during the strobe phase of a write. `bus_ds_n` and `bus_rnw` stay high.
- R4: With `cfg_style` 1, `bus_ds_n` is low during the strobe phase. `bus_rnw` is 1 for a read and 0 for a write while `bus_cs_n` is low. `bus_rd_n` and `bus_wr_n` stay high.
- R5: With `cfg_style` 2, the signalling follows R4. The strobe phase ends only in a clock in which its extension count has expired and `bus_rdy` is active. `bus_rdy` is active when high if `cfg_rdy_high`=1, and active when low otherwise.
- R6: With `cfg_mux`=1, `bus_doe` is high in every address-phase clock and `bus_dout` carries the external address. With `cfg_mux`=0, `bus_doe` is low in the address phase.
- R7: For a write, `bus_doe` is high with `bus_dout`=`req_wdata` in every clock where `bus_cs_n` is low. For a read, `bus_doe` is low while `bus_cs_n` is low.
- R8: A write accepted while `cfg_wr_en`=0 produces no chip select and no strobe. It returns `rsp_valid`=1 with `rsp_err`=1 in the next clock. Reads are unaffected by `cfg_wr_en`.
- R9: Read data is sampled from `bus_din` in the last clock of the strobe phase. With `cfg_narrow`=0 and `req_be`=2'b11, `rsp_rdata` equals that sample. Successful responses have `rsp_err`=0.
- R10: With `cfg_narrow`=1, each request moves one byte at `req_addr` on pins 7:0. `bus_be_n`=2'b10. A read returns that byte in `rsp_rdata[7:0]` with the upper byte zero, and a write drives `req_wdata` on `bus_dout`.
- R11: With `cfg_narrow`=0 and `cfg_byte_rd`=0, a read with a one-hot `req_be` goes out as a halfword read at the even address with `bus_be_n`=2'b00. The addressed byte (pins 15:8 for an odd address, 7:0 for an even one) is returned in `rsp_rdata[7:0]` and the upper byte is zero.
- R12: With `cfg_narrow`=0 and `cfg_byte_rd`=1, a one-hot byte read goes out at `req_addr`. Only the addressed lane's enable is low: `bus_be_n`=2'b01 for an odd address and 2'b10 for an even one. The byte is returned as in R11.
- R13: During and right after reset, `req_ready`=1, `bus_cs_n`, `bus_rd_n`, `bus_wr_n` and `bus_ds_n` are 1, and `bus_doe` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 = low byte) |
| req_read | input | 1 | 1 = read, 0 = write |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Write refused |
| cfg_ext_addr | input | 2 | Address phase extension |
| cfg_ext_setup | input | 2 | Setup phase extension |
| cfg_ext_strobe | input | 4 | Strobe phase extension |
| cfg_ext_hold | input | 2 | Hold phase extension |
| cfg_ext_recov | input | 4 | Recovery phase extension |
| cfg_style | input | 2 | Strobe style: 0 split, 1 data strobe, 2 host-port, 3 as 0 |
| cfg_rdy_high | input | 1 | Ready polarity in host-port style |
| cfg_mux | input | 1 | Address on data pins in address phase |
| cfg_wr_en | input | 1 | Allow write cycles |
| cfg_narrow | input | 1 | 8-bit external bus |
| cfg_byte_rd | input | 1 | Single-byte reads on 16-bit device |
| bus_addr | output | AW | External address |
| bus_be_n | output | 2 | Active-low lane enables |
| bus_dout | output | 16 | Data pins out |
| bus_doe | output | 1 | Data pins output enable |
| bus_din | input | 16 | Data pins in |
| bus_cs_n | output | 1 | Chip select |
| bus_rd_n | output | 1 | Read strobe (style 0) |
| bus_wr_n | output | 1 | Write strobe (style 0) |
| bus_ds_n | output | 1 | Data strobe (styles 1, 2) |
| bus_rnw | output | 1 | Read/not-write (styles 1, 2) |
| bus_rdy | input | 1 | Device ready (style 2) |

## Verification
The checker assumes that the configuration inputs change only while the bus is idle, with chip select and every strobe high. A strobe-style check applied in the middle of a cycle is valid only under that assumption. The host-port ready check further assumes that `bus_rdy` is sampled only during the strobe phase. The bench respects both assumptions: it rewrites the configuration only between transfers, after `req_ready` has returned. Its device model raises ready after a fixed number of strobe clocks and drives valid read data only while a strobe is low, so a capture in the wrong clock returns a visible marker value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SETUP = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    STY_SPLIT = 2'd0,
    STY_DSTRB = 2'd1,
    STY_HOST  = 2'd2,
    STY_RSVD  = 2'd3
  } style_e;

  // byte-select for the read return path
  typedef enum logic [1:0] {
    SEL_FULL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rsel_e;
endpackage

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
  import pbus_pkg::*;
#(
  parameter int SHORT_W = 2,
  parameter int LONG_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SHORT_W-1:0] ext_addr,
  input  logic [SHORT_W-1:0] ext_setup,
  input  logic [LONG_W-1:0]  ext_strb,
  input  logic [SHORT_W-1:0] ext_hold,
  input  logic [LONG_W-1:0]  ext_recov,
  input  logic               wait_rdy,
  input  logic               rdy_ok,
  output phase_e             phase,
  output logic               strb_end,
  output logic               done
);
  localparam int CNT_W = (LONG_W > SHORT_W) ? LONG_W : SHORT_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_len;
  phase_e           nxt;
  phase_e           load_ph;
  logic             cnt_zero;
  logic             adv;

  assign cnt_zero = (cnt == '0);
  assign strb_end = (phase == PH_STRB) && cnt_zero && (!wait_rdy || rdy_ok);
  assign adv      = (phase != PH_IDLE) && cnt_zero && ((phase != PH_STRB) || strb_end);
  assign done     = (phase == PH_RECOV) && cnt_zero;

  always_comb begin
    unique case (phase)
      PH_ADDR:  nxt = PH_SETUP;
      PH_SETUP: nxt = PH_STRB;
      PH_STRB:  nxt = PH_HOLD;
      PH_HOLD:  nxt = PH_RECOV;
      default:  nxt = PH_IDLE;
    endcase
    load_ph = (phase == PH_IDLE) ? PH_ADDR : nxt;
    unique case (load_ph)
      PH_ADDR:  load_len = CNT_W'(ext_addr);
      PH_SETUP: load_len = CNT_W'(ext_setup);
      PH_STRB:  load_len = CNT_W'(ext_strb);
      PH_HOLD:  load_len = CNT_W'(ext_hold);
      PH_RECOV: load_len = CNT_W'(ext_recov);
      default:  load_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if ((phase == PH_IDLE && start) || adv) begin
      phase <= load_ph;
      cnt   <= load_len;
    end else if (!cnt_zero) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pbus_lane_path.sv
module pbus_lane_path
  import pbus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     req_addr,
  input  logic [HALF_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  input  logic              req_read,
  input  logic              cfg_narrow,
  input  logic              cfg_byte_rd,
  input  logic              cfg_mux,
  input  phase_e            phase,
  input  logic              strb_end,
  input  logic [HALF_W-1:0] bus_din,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_be_n,
  output logic [HALF_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              xfer_read,
  output logic [HALF_W-1:0] rdata
);
  logic [AW-1:0]     addr_q;
  logic [HALF_W-1:0] wdata_q;
  logic [1:0]        be_q;
  rsel_e             sel_q;
  logic              read_q;
  logic [HALF_W-1:0] rdata_q;
  logic [HALF_W-1:0] addr_on_data;

  logic [AW-1:0] addr_d;
  logic [1:0]    be_d;
  rsel_e         sel_d;
  logic          byte_req;

  generate
    if (AW >= HALF_W) begin : g_trunc
      assign addr_on_data = addr_q[HALF_W-1:0];
    end else begin : g_pad
      assign addr_on_data = {{(HALF_W-AW){1'b0}}, addr_q};
    end
  endgenerate

  assign byte_req = (req_be == 2'b01) || (req_be == 2'b10);

  always_comb begin
    addr_d = req_addr;
    be_d   = ~req_be;
    sel_d  = SEL_FULL;
    if (cfg_narrow) begin
      be_d  = 2'b10;
      sel_d = SEL_LO;
    end else if (req_read && byte_req) begin
      sel_d = req_addr[0] ? SEL_HI : SEL_LO;
      if (cfg_byte_rd) begin
        be_d = req_addr[0] ? 2'b01 : 2'b10;
      end else begin
        addr_d = {req_addr[AW-1:1], 1'b0};
        be_d   = 2'b00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= 2'b11;
      sel_q   <= SEL_FULL;
      read_q  <= 1'b1;
      rdata_q <= '0;
    end else begin
      if (start) begin
        addr_q  <= addr_d;
        wdata_q <= req_wdata;
        be_q    <= be_d;
        sel_q   <= sel_d;
        read_q  <= req_read;
      end
      if (strb_end && read_q) begin
        unique case (sel_q)
          SEL_LO:  rdata_q <= {{(HALF_W-BYTE_W){1'b0}}, bus_din[BYTE_W-1:0]};
          SEL_HI:  rdata_q <= {{(HALF_W-BYTE_W){1'b0}}, bus_din[HALF_W-1:BYTE_W]};
          default: rdata_q <= bus_din;
        endcase
      end
    end
  end

  logic addr_drive;
  logic data_drive;
  assign addr_drive = cfg_mux && (phase == PH_ADDR);
  assign data_drive = !read_q &&
                      ((phase == PH_SETUP) || (phase == PH_STRB) || (phase == PH_HOLD));

  assign bus_addr  = addr_q;
  assign bus_be_n  = (phase == PH_IDLE) ? 2'b11 : be_q;
  assign bus_dout  = addr_drive ? addr_on_data : wdata_q;
  assign bus_doe   = addr_drive || data_drive;
  assign xfer_read = read_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/pbus_cycle_seq.sv
module pbus_cycle_seq
  import pbus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int SHORT_W = 2,
  parameter int LONG_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic [15:0]        req_wdata,
  input  logic [1:0]         req_be,
  input  logic               req_read,
  output logic               rsp_valid,
  output logic [15:0]        rsp_rdata,
  output logic               rsp_err,
  input  logic [SHORT_W-1:0] cfg_ext_addr,
  input  logic [SHORT_W-1:0] cfg_ext_setup,
  input  logic [LONG_W-1:0]  cfg_ext_strobe,
  input  logic [SHORT_W-1:0] cfg_ext_hold,
  input  logic [LONG_W-1:0]  cfg_ext_recov,
  input  logic [1:0]         cfg_style,
  input  logic               cfg_rdy_high,
  input  logic               cfg_mux,
  input  logic               cfg_wr_en,
  input  logic               cfg_narrow,
  input  logic               cfg_byte_rd,
  output logic [AW-1:0]      bus_addr,
  output logic [1:0]         bus_be_n,
  output logic [15:0]        bus_dout,
  output logic               bus_doe,
  input  logic [15:0]        bus_din,
  output logic               bus_cs_n,
  output logic               bus_rd_n,
  output logic               bus_wr_n,
  output logic               bus_ds_n,
  output logic               bus_rnw,
  input  logic               bus_rdy
);
  phase_e phase;
  style_e sty;
  logic   accept, refuse, start;
  logic   strb_end, done;
  logic   rdy_ok, xfer_read;
  logic   in_strb, cs_act;
  logic [15:0] rdata;

  assign sty       = (cfg_style == 2'd3) ? STY_SPLIT : style_e'(cfg_style);
  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign refuse    = accept && !req_read && !cfg_wr_en;
  assign start     = accept && !refuse;
  assign rdy_ok    = cfg_rdy_high ? bus_rdy : !bus_rdy;

  pbus_phase_seq #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ext_addr (cfg_ext_addr),
    .ext_setup(cfg_ext_setup),
    .ext_strb (cfg_ext_strobe),
    .ext_hold (cfg_ext_hold),
    .ext_recov(cfg_ext_recov),
    .wait_rdy (sty == STY_HOST),
    .rdy_ok   (rdy_ok),
    .phase    (phase),
    .strb_end (strb_end),
    .done     (done)
  );

  pbus_lane_path #(.AW(AW)) u_lane (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .req_read   (req_read),
    .cfg_narrow (cfg_narrow),
    .cfg_byte_rd(cfg_byte_rd),
    .cfg_mux    (cfg_mux),
    .phase      (phase),
    .strb_end   (strb_end),
    .bus_din    (bus_din),
    .bus_addr   (bus_addr),
    .bus_be_n   (bus_be_n),
    .bus_dout   (bus_dout),
    .bus_doe    (bus_doe),
    .xfer_read  (xfer_read),
    .rdata      (rdata)
  );

  // strobe decode from the registered phase state
  assign in_strb  = (phase == PH_STRB);
  assign cs_act   = (phase == PH_SETUP) || in_strb || (phase == PH_HOLD);
  assign bus_cs_n = !cs_act;
  assign bus_rd_n = !((sty == STY_SPLIT) && in_strb && xfer_read);
  assign bus_wr_n = !((sty == STY_SPLIT) && in_strb && !xfer_read);
  assign bus_ds_n = !((sty != STY_SPLIT) && in_strb);
  assign bus_rnw  = ((sty != STY_SPLIT) && cs_act) ? xfer_read : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= done || refuse;
      rsp_err   <= refuse;
    end
  end
  assign rsp_rdata = rdata;
endmodule

// File: rtl/pbus_cycle_seq_chk.sv
module pbus_cycle_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_read,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [1:0]    cfg_style,
  input logic          cfg_rdy_high,
  input logic          cfg_mux,
  input logic          cfg_wr_en,
  input logic [AW-1:0] bus_addr,
  input logic          bus_doe,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic          bus_ds_n,
  input logic          bus_rdy
);
  // R1
  idle_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bus_cs_n);

  // R2
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n || !bus_ds_n) |-> !bus_cs_n);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  // R3
  split_style_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_style == 2'd0 || cfg_style == 2'd3) |-> (bus_ds_n && !(!bus_rd_n && !bus_wr_n)));

  // R4
  dstrb_style_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_style == 2'd1 || cfg_style == 2'd2) |-> (bus_rd_n && bus_wr_n));

  // R5
  host_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_style == 2'd2 && $past(!bus_ds_n) && bus_ds_n) |->
      $past(cfg_rdy_high ? bus_rdy : !bus_rdy));

  // R6
  mux_only_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_doe && bus_cs_n) |-> cfg_mux);

  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_read && !cfg_wr_en) |=> (rsp_valid && rsp_err && bus_cs_n));

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
endmodule

bind pbus_cycle_seq pbus_cycle_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_read    (req_read),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .cfg_style   (cfg_style),
  .cfg_rdy_high(cfg_rdy_high),
  .cfg_mux     (cfg_mux),
  .cfg_wr_en   (cfg_wr_en),
  .bus_addr    (bus_addr),
  .bus_doe     (bus_doe),
  .bus_cs_n    (bus_cs_n),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_ds_n    (bus_ds_n),
  .bus_rdy     (bus_rdy)
);

// File: tb/tb_pbus_cycle_seq.sv
`timescale 1ns/1ps
module tb_pbus_cycle_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_read = 1'b1;
  logic        req_ready;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [1:0]  c_a = 0, c_s = 0, c_h = 0, c_sty = 0;
  logic [3:0]  c_t = 0, c_r = 0;
  logic        c_pol = 1, c_mux = 0, c_wen = 1, c_nar = 0, c_brd = 0;
  logic [15:0] bus_addr, bus_dout, bus_din;
  logic [1:0]  bus_be_n;
  logic        bus_doe, bus_cs_n, bus_rd_n, bus_wr_n, bus_ds_n, bus_rnw, bus_rdy;

  int n_chk = 0, n_fail = 0;
  int hp_wait = 0;
  int strb_cnt = 0;

  pbus_cycle_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_read(req_read),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cfg_ext_addr(c_a), .cfg_ext_setup(c_s), .cfg_ext_strobe(c_t), .cfg_ext_hold(c_h),
    .cfg_ext_recov(c_r), .cfg_style(c_sty), .cfg_rdy_high(c_pol), .cfg_mux(c_mux),
    .cfg_wr_en(c_wen), .cfg_narrow(c_nar), .cfg_byte_rd(c_brd),
    .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ds_n(bus_ds_n), .bus_rnw(bus_rnw), .bus_rdy(bus_rdy)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  // device model: data valid only while a read strobe is low
  always_comb begin
    if (!bus_rd_n || (!bus_ds_n && bus_rnw)) begin
      if (c_nar) bus_din = {8'hEE, mb(bus_addr)};
      else       bus_din = {mb(bus_addr | 16'h1), mb(bus_addr & 16'hFFFE)};
    end else begin
      bus_din = 16'hBAD0;
    end
  end
  always_ff @(posedge clk) strb_cnt <= (!bus_ds_n) ? strb_cnt + 1 : 0;
  assign bus_rdy = c_pol ? (strb_cnt >= hp_wait) : !(strb_cnt >= hp_wait);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int n_pre, n_cs, n_post, n_rd, n_wr, n_ds, n_mux, n_doe_pre, n_wd, n_doe_cs, n_rnw;
  int r_valid, r_err, r_data, f_addr, f_be;

  task automatic xfer(input logic rd, input logic [15:0] a, input logic [15:0] wd,
                      input logic [1:0] be);
    bit seen = 0;
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_read = rd; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 0;
    n_pre = 0; n_cs = 0; n_post = 0; n_rd = 0; n_wr = 0; n_ds = 0; n_mux = 0;
    n_doe_pre = 0; n_wd = 0; n_doe_cs = 0; n_rnw = 0; f_addr = -1; f_be = -1;
    while (!req_ready && guard < 300) begin
      n_rd += int'(!bus_rd_n); n_wr += int'(!bus_wr_n); n_ds += int'(!bus_ds_n);
      if (!bus_cs_n) begin
        if (!seen) begin f_addr = int'(bus_addr); f_be = int'(bus_be_n); end
        seen = 1; n_cs++;
        if (bus_doe && bus_dout == wd) n_wd++;
        if (bus_doe) n_doe_cs++;
        if (bus_rnw == rd) n_rnw++;
      end else if (!seen) begin
        n_pre++;
        if (bus_doe) n_doe_pre++;
        if (bus_doe && bus_dout == bus_addr) n_mux++;
      end else begin
        n_post++;
      end
      @(negedge clk);
      guard++;
    end
    r_valid = int'(rsp_valid); r_err = int'(rsp_err); r_data = int'(rsp_rdata);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    chk("R13", "ready in reset", int'(req_ready), 1);
    chk("R13", "strobes in reset", int'({bus_cs_n, bus_rd_n, bus_wr_n, bus_ds_n}), 15);
    chk("R13", "doe/rsp in reset", int'({bus_doe, rsp_valid}), 0);
    rst = 0;
    @(negedge clk);
    chk("R13", "idle after reset", int'({req_ready, bus_cs_n, bus_doe, rsp_valid}), 4'b1100);

    // R1..R7, R9 sweep over styles, mux, timing sets, direction
    for (int sty = 0; sty < 4; sty++) begin
      for (int mx = 0; mx < 2; mx++) begin
        for (int ts = 0; ts < 3; ts++) begin
          for (int rdi = 0; rdi < 2; rdi++) begin
            int st_len;
            logic [15:0] ad;
            logic [15:0] wd;
            c_sty = 2'(sty); c_mux = mx[0]; c_pol = mx[0];
            if (ts == 0) begin c_a = 0; c_s = 0; c_t = 0; c_h = 0; c_r = 0; hp_wait = 2; end
            else if (ts == 1) begin c_a = 3; c_s = 3; c_t = 15; c_h = 3; c_r = 15; hp_wait = 2; end
            else begin c_a = 1; c_s = 2; c_t = 5; c_h = 0; c_r = 9; hp_wait = 7; end
            ad = 16'h1200 + 16'(sty * 64 + mx * 16 + ts * 4);
            wd = 16'hA500 ^ ad;
            xfer(rdi[0], ad, wd, 2'b11);
            st_len = (sty == 2 && hp_wait > int'(c_t)) ? hp_wait + 1 : int'(c_t) + 1;
            chk("R1", "address phase", n_pre, 1 + int'(c_a));
            chk("R2", "chip select", n_cs, 3 + int'(c_s) + st_len - 1 + int'(c_h));
            chk("R1", "recovery", n_post, 1 + int'(c_r));
            if (sty == 1 || sty == 2) begin
              chk(sty == 2 ? "R5" : "R4", "data strobe", n_ds, st_len);
              chk("R4", "rd/wr idle", n_rd + n_wr, 0);
              chk("R4", "rnw", n_rnw, n_cs);
            end else begin
              chk("R3", "read strobe", n_rd, rdi != 0 ? st_len : 0);
              chk("R3", "write strobe", n_wr, rdi != 0 ? 0 : st_len);
              chk("R3", "ds idle", n_ds, 0);
            end
            chk("R6", "mux doe", n_doe_pre, mx != 0 ? n_pre : 0);
            chk("R6", "mux address", n_mux, mx != 0 ? n_pre : 0);
            if (rdi != 0) begin
              chk("R7", "read no drive", n_doe_cs, 0);
              chk("R9", "read data", r_data, int'({mb(ad | 16'h1), mb(ad)}));
            end else begin
              chk("R7", "write data", n_wd, n_cs);
            end
            chk("R9", "response", r_valid * 2 + r_err, 2);
          end
        end
      end
    end

    // R5 ready polarity low with long wait
    c_sty = 2; c_pol = 0; c_mux = 0; c_a = 0; c_s = 0; c_t = 1; c_h = 0; c_r = 0; hp_wait = 9;
    xfer(1, 16'h0040, 16'h0, 2'b11);
    chk("R5", "active-low ready wait", n_ds, 10);

    // R8 write refused
    c_sty = 0; c_wen = 0;
    xfer(0, 16'h0100, 16'h1234, 2'b11);
    chk("R8", "refused no cycle", n_cs + n_wr + n_pre, 0);
    chk("R8", "refused response", r_valid * 2 + r_err, 3);
    xfer(1, 16'h0102, 16'h0, 2'b11);
    chk("R8", "read with writes off", r_data, int'({mb(16'h0103), mb(16'h0102)}));
    chk("R8", "read with writes off ok", r_err, 0);
    c_wen = 1;

    // R10 narrow bus
    c_nar = 1;
    xfer(1, 16'h0233, 16'h0, 2'b11);
    chk("R10", "narrow read", r_data, int'(mb(16'h0233)));
    chk("R10", "narrow lanes", f_be, 2);
    chk("R10", "narrow addr", f_addr, 16'h0233);
    xfer(0, 16'h0235, 16'h005A, 2'b01);
    chk("R10", "narrow write", n_wd, n_cs);
    c_nar = 0;

    // R11 byte read without option
    c_brd = 0;
    xfer(1, 16'h0345, 16'h0, 2'b10);
    chk("R11", "odd byte", r_data, int'(mb(16'h0345)));
    chk("R11", "even addr out", f_addr, 16'h0344);
    chk("R11", "both lanes", f_be, 0);
    xfer(1, 16'h0346, 16'h0, 2'b01);
    chk("R11", "even byte", r_data, int'(mb(16'h0346)));

    // R12 byte read with option
    c_brd = 1;
    xfer(1, 16'h0457, 16'h0, 2'b10);
    chk("R12", "odd byte", r_data, int'(mb(16'h0457)));
    chk("R12", "odd addr out", f_addr, 16'h0457);
    chk("R12", "odd lane", f_be, 1);
    xfer(1, 16'h0458, 16'h0, 2'b01);
    chk("R12", "even byte", r_data, int'(mb(16'h0458)));
    chk("R12", "even lane", f_be, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule